// File: doc/BRIEF.md
# Interrupt Request Qualifier

This block sits between a set of event sources and a processor and decides when a vectored interrupt is taken. Each source has three pieces of state. The first is a pending flag, set by a rising edge on its trigger line. The second is an enable bit written by software. The third is a priority level, where a smaller value means more urgent. Two global settings apply to all sources: a global disable bit and a priority threshold. A request is taken only when all four of these hold in the same cycle: the flag is pending, the source is enabled, the disable bit is clear, and the level is allowed by the threshold.

When a request is taken, the block pulses a one-cycle take strobe and latches the number of the winning source. It then stays in service and issues no new strobe until an end-of-service pulse arrives. A request that is blocked is not lost. Its flag stays pending until software clears it with an acknowledge write. A flag that is never cleared is taken again after each end of service.

Software reaches the settings through a single-cycle write port (enable, address, data). The address map is as follows:

| Address | Meaning |
|---|---|
| 0 | Enable bits, one per source |
| 1 | Bit 0 is the global disable bit |
| 2 | Threshold |
| 3 | Acknowledge: each 1 bit clears that source's flag |
| 4 + k | Level of source k |

Top module: `irq_qual`

## Requirements
- R1: An interrupt is taken only when, in the same cycle, a source's flag is set, its enable bit (address 0, bit k) is 1, the global disable bit is 0, and its level is allowed by the threshold.
- R2: While the global disable bit (address 1, bit 0) is 1, no interrupt is taken, whatever the other conditions are.
- R3: A threshold (address 2) of 0 allows every level. A nonzero threshold allows only levels strictly below it.
- R4: A flag that is set while some other condition is false stays pending. It is taken once all conditions become true.
- R5: A rising edge on trig_i[k] sets flag k at the next clock edge. A trigger that is held high sets the flag only once.
- R6: A write to address 3 clears each flag whose data bit is 1. A new rising edge in the same cycle wins over the clear. A flag is cleared in no other way, so an uncleared flag is taken again after each end of service.
- R7: When an interrupt is taken, active_id_o shows the chosen source and holds that value until the next take.
- R8: Among the qualifying sources, the one with the lowest level value wins. A tie goes to the lower source number.
- R9: take_o is a one-cycle pulse, asserted in the cycle after a request qualifies. No further pulse is issued until eos_i is pulsed. eos_i has no effect while nothing is in service.
- R10: After reset, all flags, enable bits, levels, the threshold and the disable bit are 0, and take_o and active_id_o are 0. Address 4+k writes the level of source k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Register write data |
| trig_i | input | NUM_SRC | Per-source event lines, sensed on rising edge |
| eos_i | input | 1 | End-of-service pulse |
| take_o | output | 1 | One-cycle take strobe |
| active_id_o | output | ID_W | Number of the source last taken |
| flags_o | output | NUM_SRC | Pending flags |

## Verification
The bench builds the block with six sources and a 2-bit level. With only four levels, random levels collide often, so tie-breaking by source number is exercised regularly. With a 2-bit level, every threshold value, including the unmasked value 0, is reachable by random writes. Directed phases cover each blocking condition in turn, held triggers, and re-take of an unacknowledged flag. A long random phase then mixes writes, triggers and end-of-service pulses.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;
    localparam int unsigned ADDR_ARM      = 0;
    localparam int unsigned ADDR_CTRL     = 1;
    localparam int unsigned ADDR_THR      = 2;
    localparam int unsigned ADDR_ACK      = 3;
    localparam int unsigned ADDR_LVL_BASE = 4;

    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/irq_qual_regs.sv
module irq_qual_regs
    import irq_qual_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned LVL_W   = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [DATA_W-1:0]               wr_data_i,
    output logic [NUM_SRC-1:0]              arm_o,
    output logic                            dis_o,
    output logic [LVL_W-1:0]                thr_o,
    output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_o,
    output logic [NUM_SRC-1:0]              ack_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0]            arm;
        logic                          dis;
        logic [LVL_W-1:0]              thr;
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        ack_o  = '0;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(ADDR_ARM))  regs_d.arm = wr_data_i[NUM_SRC-1:0];
            if (wr_addr_i == ADDR_W'(ADDR_CTRL)) regs_d.dis = wr_data_i[0];
            if (wr_addr_i == ADDR_W'(ADDR_THR))  regs_d.thr = wr_data_i[LVL_W-1:0];
            if (wr_addr_i == ADDR_W'(ADDR_ACK))  ack_o      = wr_data_i[NUM_SRC-1:0];
            for (int k = 0; k < NUM_SRC; k++) begin
                if (wr_addr_i == ADDR_W'(ADDR_LVL_BASE + k))
                    regs_d.lvl[k] = wr_data_i[LVL_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign arm_o = regs_q.arm;
    assign dis_o = regs_q.dis;
    assign thr_o = regs_q.thr;
    assign lvl_o = regs_q.lvl;
endmodule

// File: rtl/irq_qual_flags.sv
module irq_qual_flags #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0] trig_prev;
        logic [NUM_SRC-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [NUM_SRC-1:0] rise;

    always_comb begin
        rise           = trig_i & ~st_q.trig_prev;
        st_d.trig_prev = trig_i;
        // a fresh event outranks a clear issued in the same cycle
        st_d.flags     = (st_q.flags & ~ack_i) | rise;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/irq_qual_select.sv
module irq_qual_select
    import irq_qual_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned LVL_W   = 4,
    localparam int unsigned ID_W   = id_width(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]            flags_i,
    input  logic [NUM_SRC-1:0]            arm_i,
    input  logic                          dis_i,
    input  logic [LVL_W-1:0]              thr_i,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_i,
    output logic                          any_o,
    output logic [ID_W-1:0]               id_o
);
    logic [NUM_SRC-1:0] elig;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_qual
        logic lvl_ok;
        assign lvl_ok  = (thr_i == '0) || (lvl_i[k] < thr_i);
        assign elig[k] = flags_i[k] & arm_i[k] & ~dis_i & lvl_ok;
    end

    logic [LVL_W-1:0] best_lvl;
    always_comb begin
        any_o    = 1'b0;
        id_o     = '0;
        best_lvl = '0;
        // ascending scan with strict compare keeps the lower index on ties
        for (int k = 0; k < NUM_SRC; k++) begin
            if (elig[k] && (!any_o || lvl_i[k] < best_lvl)) begin
                any_o    = 1'b1;
                id_o     = ID_W'(k);
                best_lvl = lvl_i[k];
            end
        end
    end
endmodule

// File: rtl/irq_qual.sv
module irq_qual
    import irq_qual_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned LVL_W   = 4,
    parameter int unsigned DATA_W  = 16,
    localparam int unsigned ADDR_W = $clog2(NUM_SRC + ADDR_LVL_BASE),
    localparam int unsigned ID_W   = id_width(NUM_SRC)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [NUM_SRC-1:0] trig_i,
    input  logic               eos_i,
    output logic               take_o,
    output logic [ID_W-1:0]    active_id_o,
    output logic [NUM_SRC-1:0] flags_o
);
    logic [NUM_SRC-1:0]            arm, ack, flags;
    logic                          glob_dis;
    logic [LVL_W-1:0]              thr;
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic                          any_elig;
    logic [ID_W-1:0]               win_id;

    irq_qual_regs #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .arm_o(arm), .dis_o(glob_dis), .thr_o(thr), .lvl_o(lvl), .ack_o(ack)
    );

    irq_qual_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i),
        .ack_i(ack), .flags_o(flags)
    );

    irq_qual_select #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_sel (
        .flags_i(flags), .arm_i(arm), .dis_i(glob_dis), .thr_i(thr),
        .lvl_i(lvl), .any_o(any_elig), .id_o(win_id)
    );

    typedef struct packed {
        logic            take;
        logic            busy;
        logic [ID_W-1:0] id;
    } svc_t;

    svc_t svc_d, svc_q;

    always_comb begin
        svc_d      = svc_q;
        svc_d.take = any_elig & ~svc_q.busy;
        if (svc_d.take) begin
            svc_d.busy = 1'b1;
            svc_d.id   = win_id;
        end else if (eos_i) begin
            svc_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) svc_q <= '0;
        else         svc_q <= svc_d;
    end

    assign take_o      = svc_q.take;
    assign active_id_o = svc_q.id;
    assign flags_o     = flags;
endmodule

// File: rtl/irq_qual_chk.sv
module irq_qual_chk
    import irq_qual_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned ID_W    = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               take_i,
    input logic [ID_W-1:0]    id_i,
    input logic [NUM_SRC-1:0] flags_i,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic               dis_i
);
    assert_take_needs_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> |(($past(flags_i) >> id_i) & NUM_SRC'(1)));

    assert_disable_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> !$past(dis_i));

    assert_flag_clears_on_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|($past(flags_i) & ~flags_i)) |-> $past(wr_en_i && wr_addr_i == ADDR_W'(ADDR_ACK)));

    assert_id_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_i |-> $stable(id_i));

    assert_take_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |=> !take_i);
endmodule

bind irq_qual irq_qual_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_o), .id_i(active_id_o),
    .flags_i(flags_o), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .dis_i(glob_dis)
);

// File: tb/irq_qual_tb.sv
module irq_qual_tb;
    localparam int N  = 6;
    localparam int LW = 2;
    localparam int DW = 16;
    localparam int AW = $clog2(N + 4);
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [N-1:0]  trig = '0;
    logic          eos = 1'b0;
    logic          take;
    logic [IW-1:0] act_id;
    logic [N-1:0]  flags;

    always #5 clk = ~clk;

    irq_qual #(.NUM_SRC(N), .LVL_W(LW), .DATA_W(DW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .trig_i(trig), .eos_i(eos),
        .take_o(take), .active_id_o(act_id), .flags_o(flags)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic [N-1:0]  m_arm = '0, m_flags = '0, m_trigp = '0;
    logic          m_dis = 0, m_busy = 0, m_take = 0;
    logic [LW-1:0] m_thr = '0;
    logic [LW-1:0] m_lvl [N];
    logic [IW-1:0] m_id = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N:0] pick();
        logic [N:0] r = '0;
        logic [LW-1:0] best = '0;
        bit found = 0;
        for (int k = 0; k < N; k++) begin
            bit ok = m_flags[k] && m_arm[k] && !m_dis && (m_thr == 0 || m_lvl[k] < m_thr);
            if (ok && (!found || m_lvl[k] < best)) begin
                found = 1; best = m_lvl[k]; r = {1'b1, N'(k)};
            end
        end
        return r;
    endfunction

    task automatic tick();
        logic [N:0] w;
        logic [N-1:0] ack;
        @(posedge clk);
        w = pick();
        ack = (wr_en && wr_addr == AW'(3)) ? wr_data[N-1:0] : '0;
        m_take = w[N] && !m_busy;
        if (m_take) begin m_busy = 1; m_id = IW'(w[N-1:0]); end
        else if (eos) m_busy = 0;
        m_flags = (m_flags & ~ack) | (trig & ~m_trigp);
        m_trigp = trig;
        if (wr_en) begin
            if (wr_addr == 0) m_arm = wr_data[N-1:0];
            if (wr_addr == 1) m_dis = wr_data[0];
            if (wr_addr == 2) m_thr = wr_data[LW-1:0];
            for (int k = 0; k < N; k++) if (wr_addr == AW'(4 + k)) m_lvl[k] = wr_data[LW-1:0];
        end
        @(negedge clk);
        check(take === m_take, "R1/R9 take", int'(take), int'(m_take));
        check(act_id === m_id, "R7/R8 id", int'(act_id), int'(m_id));
        check(flags === m_flags, "R5/R6 flags", int'(flags), int'(m_flags));
        wr_en = 0; eos = 0;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic expect_take(input int id, input string tag);
        bit seen = 0;
        for (int i = 0; i < 6 && !seen; i++) begin
            tick();
            if (take) seen = 1;
        end
        check(seen && act_id == IW'(id), tag, int'(act_id), id);
    endtask

    task automatic expect_none(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin tick(); if (take) seen = 1; end
        check(!seen, tag, int'(seen), 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < N; k++) m_lvl[k] = '0;
        repeat (3) @(negedge clk);
        // R10: reset values
        check(take === 0 && act_id === 0 && flags === 0, "R10 reset", int'(flags), 0);
        rst_n = 1;
        @(negedge clk);
        wr(4 + 1, 3); wr(4 + 2, 1); wr(4 + 4, 1);
        // R5: held triggers set flags once; R1: no take while disarmed
        trig = 6'b010100;
        tick();
        check(flags == 6'b010100, "R5 set", int'(flags), 6'b010100);
        expect_none(5, "R1 disarmed");
        // R2: global disable blocks everything
        wr(1, 1); wr(0, 6'h3f);
        expect_none(5, "R2 disabled");
        // R3: threshold 1 masks level 1
        wr(2, 1); wr(1, 0);
        expect_none(5, "R3 masked");
        // R4/R8: unmask, pending flags served, tie goes to source 2
        wr(2, 0);
        expect_take(2, "R8 tie lower index");
        // R9: no second strobe while busy
        expect_none(5, "R9 busy");
        wr(3, 6'b000100);
        check(flags == 6'b010000, "R6 ack clears, R5 held trigger no reset", int'(flags), 6'b010000);
        eos = 1;
        expect_take(4, "R4 pending after eos");
        // R6: uncleared flag re-requests
        eos = 1; tick();
        expect_take(4, "R6 retake");
        wr(3, 6'b010000); eos = 1; tick();
        expect_none(4, "R6 acked quiet");
        // R9: eos while idle changes nothing
        eos = 1; tick();
        check(!take, "R9 idle eos", int'(take), 0);
        // R3/R8: nonzero threshold admits lower level, lowest wins
        trig = 0; tick();
        wr(2, 2); wr(4 + 5, 0);
        trig = 6'b100010; tick();
        expect_take(5, "R3 R8 lowest level");
        wr(3, 6'h3f); eos = 1; tick(); trig = 0;
        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 3) == 0) begin
                int a = $urandom_range(0, N + 3);
                int d = $urandom;
                if (a == 1 && $urandom_range(0, 3) != 0) d = 0;
                wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
            end
            if ($urandom_range(0, 2) == 0) trig = N'($urandom);
            eos = ($urandom_range(0, 4) == 0);
            tick();
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule